// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block is a small two-dimensional drawing engine for an 8-bit-per-pixel frame store. Software programs it through a word-wide register port and it drives a single pixel-wide memory port. It performs two operations: a solid rectangle fill with a foreground colour under a per-bit plane mask, and a screen-to-screen rectangle copy. Both operations only touch pixels that fall inside an inclusive clip window.

Operations are launched by register side effects instead of by a command register. A fill starts on the fourth write to the rectangle register: the writes give the start corner and then the end corner, each as y first and then x. A copy starts when software reads the blit register. That read returns zero when the engine takes the copy, and it returns a refusal word when the engine is still busy with earlier work. A copy walks its pixels in forward or reverse raster order, chosen so that overlapping source and destination areas copy correctly.

Each launch takes a private copy of the coordinates, clip window, colour and mask. Software may therefore reprogram the registers while an operation runs.

Top module: `rect_engine`

## Requirements
- R1: After reset the engine is idle. A STATUS read (address 0) returns 0, and `mem_we` and `mem_re` stay low.
- R2: Writes to RECT (address 3) carry one coordinate in bits [XW-1:0] and are taken in the order y-start, x-start, y-end, x-end. The fourth write launches a fill of columns x-start..x-end-1 and rows y-start..y-end-1. The fill visits one pixel per cycle in rows from the top and left to right within a row. Each pixel is written with FG (address 8, bits [PW-1:0]) as data and PMASK (address 9, bits [PW-1:0]) as the per-bit write mask.
- R3: A fill whose end x is not above its start x, or whose end y is not above its start y, is accepted but makes no memory access and never sets busy. The same holds for a copy whose corner B lies left of or above corner A.
- R4: A read of BLIT (address 2) while idle launches a copy and returns 0. The source is the inclusive box from SRC_A (address 4) to SRC_B (address 5). The destination starts at DST_A (address 6) and has the source's size. DST_B (address 7) takes writes but does not affect the copy. Copied pixels are written with all mask bits set.
- R5: A copy runs forward, from top-left to bottom-right, when the destination row is above the source row, or when the rows are equal and the destination column is not right of the source column. Otherwise it runs in reverse, from bottom-right to top-left. The final image equals the original source area placed at the destination.
- R6: A pixel whose destination lies outside the inclusive window from CLIP_LO (address 10) to CLIP_HI (address 11) is skipped, with no memory read and no memory write. CLIP_HI resets to all ones and CLIP_LO resets to zero.
- R7: STATUS bit 28 reads 1 from the cycle after a non-empty launch until the last pixel access has been issued.
- R8: A BLIT read while busy returns 0xB000_0000 (bits 31, 29 and 28) and leaves the running operation unchanged. A fourth RECT write while busy is refused in the same way. After a refusal, DRAW (address 1) reads bits 31 and 29 set until the next fill trigger is accepted. DRAW bit 28 mirrors busy.
- R9: SRC_A, SRC_B, DST_A, DST_B, CLIP_LO and CLIP_HI each pack x in bits [XW-1:0] and y in bits [16+YW-1:16].
- R10: The pixel address is {y, x}, so y fills the upper YW bits. For each copied pixel the engine asserts `mem_re` at the source address, takes `mem_rdata` one cycle later, and writes it to the destination in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a BLIT read has a side effect) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| mem_we | output | 1 | Pixel write strobe |
| mem_re | output | 1 | Pixel read strobe |
| mem_addr | output | XW+YW | Pixel address {y, x} |
| mem_wdata | output | PW | Pixel write data |
| mem_wmask | output | PW | Per-bit write enable for `mem_wdata` |
| mem_rdata | input | PW | Pixel read data, one cycle after `mem_re` |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high in the same cycle. They also assume that the memory returns read data exactly one cycle after `mem_re`, and that rectangles are small enough that no coordinate sum wraps past the coordinate width. The stimulus stays within these limits: every register access goes through a task that raises one strobe for one cycle. The bench memory model is a registered array with a fixed one-cycle read. All rectangles, including the overlapping copies, lie wholly inside the 32 by 32 test surface.

// File: rtl/rect_engine_pkg.sv
package rect_engine_pkg;
  typedef enum logic [3:0] {
    RA_STATUS  = 4'd0,
    RA_DRAW    = 4'd1,
    RA_BLIT    = 4'd2,
    RA_RECT    = 4'd3,
    RA_SRC_A   = 4'd4,
    RA_SRC_B   = 4'd5,
    RA_DST_A   = 4'd6,
    RA_DST_B   = 4'd7,
    RA_FG      = 4'd8,
    RA_PMASK   = 4'd9,
    RA_CLIP_LO = 4'd10,
    RA_CLIP_HI = 4'd11
  } reg_addr_e;

  localparam int BUSY_BIT  = 28;
  localparam int REF_HI    = 31;
  localparam int REF_LO    = 29;
  localparam int YPOS      = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PIX  = 2'd1,
    ST_CWR  = 2'd2
  } eng_state_e;
endpackage

// File: rtl/rect_engine_regs.sv
module rect_engine_regs
  import rect_engine_pkg::*;
#(
  parameter int XW = 11,
  parameter int YW = 11,
  parameter int PW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [3:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  output logic [DW-1:0] rdata,
  output logic          fill_go,
  output logic          copy_go,
  output logic [XW-1:0] fill_xs,
  output logic [YW-1:0] fill_ys,
  output logic [XW-1:0] fill_xe,
  output logic [YW-1:0] fill_ye,
  output logic [XW-1:0] src_ax,
  output logic [YW-1:0] src_ay,
  output logic [XW-1:0] src_bx,
  output logic [YW-1:0] src_by,
  output logic [XW-1:0] dst_ax,
  output logic [YW-1:0] dst_ay,
  output logic [XW-1:0] clip_lx,
  output logic [YW-1:0] clip_ly,
  output logic [XW-1:0] clip_hx,
  output logic [YW-1:0] clip_hy,
  output logic [PW-1:0] fg,
  output logic [PW-1:0] pm
);
  logic [1:0]    vtx_q, vtx_d;
  logic          ref_q, ref_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          rect_wr, fill_trig, blit_rd;
  logic [XW-1:0] wx;
  logic [YW-1:0] wy;
  logic          unused_wdata;

  assign wx           = wdata[XW-1:0];
  assign wy           = wdata[YPOS +: YW];
  assign unused_wdata = ^wdata;

  assign rect_wr   = wr_en && (addr == RA_RECT);
  assign fill_trig = rect_wr && (vtx_q == 2'd3);
  assign blit_rd   = rd_en && (addr == RA_BLIT);
  assign fill_go   = fill_trig && !busy;
  assign copy_go   = blit_rd && !busy;
  assign fill_xe   = wdata[XW-1:0];
  assign rdata     = rdata_q;

  always_comb begin
    vtx_d   = vtx_q;
    ref_d   = ref_q;
    rdata_d = rdata_q;
    if (rect_wr) vtx_d = vtx_q + 2'd1;
    if (fill_trig) ref_d = busy;
    if (rd_en) begin
      rdata_d = '0;
      case (addr)
        RA_STATUS: rdata_d[BUSY_BIT] = busy;
        RA_DRAW: begin
          rdata_d[BUSY_BIT] = busy;
          rdata_d[REF_HI]   = ref_q;
          rdata_d[REF_LO]   = ref_q;
        end
        RA_BLIT: begin
          rdata_d[BUSY_BIT] = busy;
          rdata_d[REF_HI]   = busy;
          rdata_d[REF_LO]   = busy;
        end
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vtx_q   <= '0;
      ref_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      vtx_q   <= vtx_d;
      ref_q   <= ref_d;
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_ys <= '0; fill_xs <= '0; fill_ye <= '0;
      src_ax  <= '0; src_ay  <= '0; src_bx  <= '0; src_by <= '0;
      dst_ax  <= '0; dst_ay  <= '0;
      clip_lx <= '0; clip_ly <= '0; clip_hx <= '1; clip_hy <= '1;
      fg      <= '0; pm      <= '1;
    end else if (wr_en) begin
      if (rect_wr && vtx_q == 2'd0) fill_ys <= wdata[YW-1:0];
      if (rect_wr && vtx_q == 2'd1) fill_xs <= wx;
      if (rect_wr && vtx_q == 2'd2) fill_ye <= wdata[YW-1:0];
      if (addr == RA_SRC_A)   begin src_ax  <= wx; src_ay  <= wy; end
      if (addr == RA_SRC_B)   begin src_bx  <= wx; src_by  <= wy; end
      if (addr == RA_DST_A)   begin dst_ax  <= wx; dst_ay  <= wy; end
      if (addr == RA_CLIP_LO) begin clip_lx <= wx; clip_ly <= wy; end
      if (addr == RA_CLIP_HI) begin clip_hx <= wx; clip_hy <= wy; end
      if (addr == RA_FG)    fg <= wdata[PW-1:0];
      if (addr == RA_PMASK) pm <= wdata[PW-1:0];
    end
  end

  // R8: a blit read while busy answers with both refusal bits
  a_r8_blit_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == RA_BLIT && busy) |=> (rdata[REF_HI] && rdata[REF_LO]));

  // R4: a blit read while idle is accepted with a zero word
  a_r4_blit_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == RA_BLIT && !busy) |=> (rdata == '0));
endmodule

// File: rtl/rect_engine_walk.sv
module rect_engine_walk #(
  parameter int XW = 11,
  parameter int YW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          fwd_in,
  input  logic [XW-1:0] wm1_in,
  input  logic [YW-1:0] hm1_in,
  input  logic          step,
  output logic [XW-1:0] ox,
  output logic [YW-1:0] oy,
  output logic          last
);
  logic          fwd_q, fwd_d;
  logic [XW-1:0] wm1_q, wm1_d, ox_q, ox_d;
  logic [YW-1:0] hm1_q, hm1_d, oy_q, oy_d;

  assign ox   = ox_q;
  assign oy   = oy_q;
  assign last = fwd_q ? (ox_q == wm1_q && oy_q == hm1_q)
                      : (ox_q == '0 && oy_q == '0);

  always_comb begin
    fwd_d = fwd_q;
    wm1_d = wm1_q;
    hm1_d = hm1_q;
    ox_d  = ox_q;
    oy_d  = oy_q;
    if (load) begin
      fwd_d = fwd_in;
      wm1_d = wm1_in;
      hm1_d = hm1_in;
      ox_d  = fwd_in ? '0 : wm1_in;
      oy_d  = fwd_in ? '0 : hm1_in;
    end else if (step && !last) begin
      if (fwd_q) begin
        if (ox_q == wm1_q) begin
          ox_d = '0;
          oy_d = oy_q + 1'b1;
        end else begin
          ox_d = ox_q + 1'b1;
        end
      end else begin
        if (ox_q == '0) begin
          ox_d = wm1_q;
          oy_d = oy_q - 1'b1;
        end else begin
          ox_d = ox_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_q <= 1'b1;
      wm1_q <= '0;
      hm1_q <= '0;
      ox_q  <= '0;
      oy_q  <= '0;
    end else begin
      fwd_q <= fwd_d;
      wm1_q <= wm1_d;
      hm1_q <= hm1_d;
      ox_q  <= ox_d;
      oy_q  <= oy_d;
    end
  end

  // R5: the walk never leaves the box in either direction
  a_r5_walk_in_box: assert property (@(posedge clk) disable iff (!rst_n)
    (ox_q <= wm1_q) && (oy_q <= hm1_q));
endmodule

// File: rtl/rect_engine.sv
module rect_engine
  import rect_engine_pkg::*;
#(
  parameter int XW = 11,
  parameter int YW = 11,
  parameter int PW = 8,
  localparam int AW = XW + YW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [PW-1:0] mem_wdata,
  output logic [PW-1:0] mem_wmask,
  input  logic [PW-1:0] mem_rdata
);
  logic rst_s0, rst_s1, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end
  assign rst_core_n = rst_s1;

  logic          busy, fill_go, copy_go;
  logic [XW-1:0] f_xs, f_xe, s_ax, s_bx, d_ax, c_lx, c_hx;
  logic [YW-1:0] f_ys, f_ye, s_ay, s_by, d_ay, c_ly, c_hy;
  logic [PW-1:0] fg, pm;

  rect_engine_regs #(.XW(XW), .YW(YW), .PW(PW), .DW(32)) regs_i (
    .clk(clk), .rst_n(rst_core_n), .wr_en(reg_wr), .rd_en(reg_rd),
    .addr(reg_addr), .wdata(reg_wdata), .busy(busy), .rdata(reg_rdata),
    .fill_go(fill_go), .copy_go(copy_go),
    .fill_xs(f_xs), .fill_ys(f_ys), .fill_xe(f_xe), .fill_ye(f_ye),
    .src_ax(s_ax), .src_ay(s_ay), .src_bx(s_bx), .src_by(s_by),
    .dst_ax(d_ax), .dst_ay(d_ay),
    .clip_lx(c_lx), .clip_ly(c_ly), .clip_hx(c_hx), .clip_hy(c_hy),
    .fg(fg), .pm(pm)
  );

  logic go_fill, go_copy, launch, fwd_sel;
  logic [XW-1:0] wm1_sel;
  logic [YW-1:0] hm1_sel;

  assign go_fill = fill_go && (f_xe > f_xs) && (f_ye > f_ys);
  assign go_copy = copy_go && (s_bx >= s_ax) && (s_by >= s_ay);
  assign launch  = go_fill || go_copy;
  assign fwd_sel = go_fill || (d_ay < s_ay) || ((d_ay == s_ay) && (d_ax <= s_ax));
  assign wm1_sel = go_fill ? (f_xe - f_xs - 1'b1) : (s_bx - s_ax);
  assign hm1_sel = go_fill ? (f_ye - f_ys - 1'b1) : (s_by - s_ay);

  eng_state_e    state_q, state_d;
  logic          op_copy_q;
  logic [XW-1:0] sbx_q, dbx_q, clx_q, chx_q, ox;
  logic [YW-1:0] sby_q, dby_q, cly_q, chy_q, oy;
  logic [PW-1:0] fg_q, pm_q;
  logic          step, last;

  rect_engine_walk #(.XW(XW), .YW(YW)) walk_i (
    .clk(clk), .rst_n(rst_core_n), .load(launch), .fwd_in(fwd_sel),
    .wm1_in(wm1_sel), .hm1_in(hm1_sel), .step(step),
    .ox(ox), .oy(oy), .last(last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_copy_q <= 1'b0;
      sbx_q <= '0; sby_q <= '0; dbx_q <= '0; dby_q <= '0;
      clx_q <= '0; cly_q <= '0; chx_q <= '0; chy_q <= '0;
      fg_q  <= '0; pm_q  <= '0;
    end else if (launch) begin
      op_copy_q <= go_copy;
      sbx_q <= s_ax;
      sby_q <= s_ay;
      dbx_q <= go_copy ? d_ax : f_xs;
      dby_q <= go_copy ? d_ay : f_ys;
      clx_q <= c_lx; cly_q <= c_ly; chx_q <= c_hx; chy_q <= c_hy;
      fg_q  <= fg;   pm_q  <= pm;
    end
  end

  logic [XW-1:0] px_dx, px_sx;
  logic [YW-1:0] px_dy, px_sy;
  logic          in_clip;

  assign px_dx   = dbx_q + ox;
  assign px_dy   = dby_q + oy;
  assign px_sx   = sbx_q + ox;
  assign px_sy   = sby_q + oy;
  assign in_clip = (px_dx >= clx_q) && (px_dx <= chx_q) &&
                   (px_dy >= cly_q) && (px_dy <= chy_q);
  assign busy    = (state_q != ST_IDLE);

  always_comb begin
    state_d   = state_q;
    step      = 1'b0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = {px_dy, px_dx};
    mem_wdata = fg_q;
    mem_wmask = pm_q;
    case (state_q)
      ST_IDLE: if (launch) state_d = ST_PIX;
      ST_PIX: begin
        if (op_copy_q && in_clip) begin
          mem_re   = 1'b1;
          mem_addr = {px_sy, px_sx};
          state_d  = ST_CWR;
        end else begin
          mem_we = in_clip;
          step   = 1'b1;
          if (last) state_d = ST_IDLE;
        end
      end
      ST_CWR: begin
        mem_we    = 1'b1;
        mem_wdata = mem_rdata;
        mem_wmask = '1;
        step      = 1'b1;
        state_d   = last ? ST_IDLE : ST_PIX;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R10: every source read is followed by a write in the next cycle
  a_r10_read_then_write: assert property (@(posedge clk) disable iff (!rst_core_n)
    mem_re |=> mem_we);

  // R6: no write lands outside the captured clip window
  a_r6_write_in_clip: assert property (@(posedge clk) disable iff (!rst_core_n)
    mem_we |-> (mem_addr[XW-1:0] >= clx_q && mem_addr[XW-1:0] <= chx_q &&
                mem_addr[AW-1:XW] >= cly_q && mem_addr[AW-1:XW] <= chy_q));

  // R3: an accepted but empty fill leaves the engine idle
  a_r3_empty_stays_idle: assert property (@(posedge clk) disable iff (!rst_core_n)
    (fill_go && !(f_xe > f_xs && f_ye > f_ys)) |=> !busy);

  // R8: a refused blit leaves the captured operation untouched
  a_r8_refusal_keeps_op: assert property (@(posedge clk) disable iff (!rst_core_n)
    (busy && reg_rd && reg_addr == RA_BLIT) |=>
      ($stable(op_copy_q) && $stable(dbx_q) && $stable(dby_q) && $stable(sbx_q)));
endmodule

// File: tb/rect_engine_tb_top.sv
`timescale 1ns/1ps
module rect_engine_tb_top;
  import rect_engine_pkg::*;

  localparam int XW = 5;
  localparam int YW = 5;
  localparam int PW = 8;
  localparam int AW = XW + YW;
  localparam int NPIX = 1 << AW;

  typedef struct packed {
    logic       cp;
    logic [4:0] ax, ay, bx, by, cx, cy, clx, cly, chx, chy;
    logic [7:0] fg, pm;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 5'd2,  5'd3,  5'd7,  5'd6,  5'd0,  5'd0,  5'd0,  5'd0,  5'd31, 5'd31, 8'h5A, 8'hFF},
    '{1'b0, 5'd0,  5'd0,  5'd4,  5'd4,  5'd0,  5'd0,  5'd0,  5'd0,  5'd31, 5'd31, 8'hC3, 8'h0F},
    '{1'b0, 5'd10, 5'd10, 5'd20, 5'd14, 5'd0,  5'd0,  5'd12, 5'd11, 5'd15, 5'd12, 8'h77, 8'hFF},
    '{1'b1, 5'd2,  5'd2,  5'd6,  5'd4,  5'd4,  5'd3,  5'd0,  5'd0,  5'd31, 5'd31, 8'h00, 8'hFF},
    '{1'b1, 5'd8,  5'd8,  5'd12, 5'd10, 5'd7,  5'd7,  5'd0,  5'd0,  5'd31, 5'd31, 8'h00, 8'h0F},
    '{1'b1, 5'd20, 5'd20, 5'd25, 5'd20, 5'd22, 5'd20, 5'd0,  5'd0,  5'd31, 5'd31, 8'h00, 8'hFF},
    '{1'b1, 5'd0,  5'd20, 5'd5,  5'd25, 5'd10, 5'd20, 5'd12, 5'd21, 5'd13, 5'd23, 8'h00, 8'hFF},
    '{1'b1, 5'd20, 5'd25, 5'd25, 5'd26, 5'd18, 5'd25, 5'd0,  5'd0,  5'd31, 5'd31, 8'h00, 8'hFF}
  };

  logic          clk, rst_n;
  logic          reg_wr, reg_rd;
  logic [3:0]    reg_addr;
  logic [31:0]   reg_wdata, reg_rdata;
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_addr;
  logic [PW-1:0] mem_wdata, mem_wmask, mem_rdata;

  rect_engine #(.XW(XW), .YW(YW), .PW(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wmask(mem_wmask), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  logic [PW-1:0] mem [NPIX];
  logic [PW-1:0] expm [NPIX];
  logic [PW-1:0] snap [NPIX];
  int            wr_log [4096];
  int            wr_cnt, acc_cnt;
  int            checks, fails;

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= (mem_wdata & mem_wmask) | (mem[mem_addr] & ~mem_wmask);
      if (wr_cnt < 4096) wr_log[wr_cnt] <= int'(mem_addr);
      wr_cnt  <= wr_cnt + 1;
      acc_cnt <= acc_cnt + 1;
    end
    if (mem_re) begin
      mem_rdata <= mem[mem_addr];
      acc_cnt   <= acc_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] pack(input int x, input int y);
    return (32'(y) << YPOS) | 32'(x);
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    int n;
    n = 0;
    do begin
      rd(RA_STATUS, s);
      n++;
    end while (s[BUSY_BIT] && n < 4000);
    if (s[BUSY_BIT]) check(1'b0, req, "engine never went idle", 1, 0);
  endtask

  task automatic cmp_mem(input string req);
    int bad, first;
    bad = 0; first = -1;
    for (int i = 0; i < NPIX; i++)
      if (mem[i] !== expm[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    check(bad == 0, req, $sformatf("image mismatch count (first at %0d)", first), bad, 0);
  endtask

  // model of one operation from the requirements; returns accesses and first write
  task automatic model(input vec_t v, output int n_acc, output int first_wr);
    int w, h, sx, sy, dx, dy, ffirst, flast;
    bit fwd;
    n_acc = 0; ffirst = -1; flast = -1;
    if (!v.cp) begin
      for (int y = int'(v.ay); y < int'(v.by); y++)
        for (int x = int'(v.ax); x < int'(v.bx); x++)
          if (x >= v.clx && x <= v.chx && y >= v.cly && y <= v.chy) begin
            expm[y*32+x] = (v.fg & v.pm) | (expm[y*32+x] & ~v.pm);
            n_acc++;
            if (ffirst < 0) ffirst = y*32+x;
          end
      first_wr = ffirst;
    end else begin
      w = int'(v.bx) - int'(v.ax) + 1;
      h = int'(v.by) - int'(v.ay) + 1;
      fwd = (v.cy < v.ay) || ((v.cy == v.ay) && (v.cx <= v.ax));
      for (int i = 0; i < NPIX; i++) snap[i] = expm[i];
      for (int oy = 0; oy < h; oy++)
        for (int ox = 0; ox < w; ox++) begin
          sx = int'(v.ax) + ox; sy = int'(v.ay) + oy;
          dx = int'(v.cx) + ox; dy = int'(v.cy) + oy;
          if (dx >= v.clx && dx <= v.chx && dy >= v.cly && dy <= v.chy) begin
            expm[dy*32+dx] = snap[sy*32+sx];
            n_acc += 2;
            if (ffirst < 0) ffirst = dy*32+dx;
            flast = dy*32+dx;
          end
        end
      first_wr = fwd ? ffirst : flast;
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int n_acc, first_wr, acc0, wr0;
    logic [31:0] r;
    string tag;
    model(v, n_acc, first_wr);
    wr(RA_FG, 32'(v.fg));
    wr(RA_PMASK, 32'(v.pm));
    wr(RA_CLIP_LO, pack(v.clx, v.cly));
    wr(RA_CLIP_HI, pack(v.chx, v.chy));
    if (!v.cp) begin
      tag = "R2 R6 R9";
      wr(RA_RECT, 32'(v.ay));
      wr(RA_RECT, 32'(v.ax));
      wr(RA_RECT, 32'(v.by));
      acc0 = acc_cnt; wr0 = wr_cnt;
      wr(RA_RECT, 32'(v.bx));
    end else begin
      tag = "R4 R5 R6 R9 R10";
      wr(RA_SRC_A, pack(v.ax, v.ay));
      wr(RA_SRC_B, pack(v.bx, v.by));
      wr(RA_DST_A, pack(v.cx, v.cy));
      wr(RA_DST_B, pack(31, 31));
      acc0 = acc_cnt; wr0 = wr_cnt;
      rd(RA_BLIT, r);
      check(r == 32'h0, "R4", $sformatf("vec %0d blit accept word", idx), int'(r), 0);
    end
    wait_idle("R7");
    cmp_mem(tag);
    check(acc_cnt - acc0 == n_acc, "R6",
          $sformatf("vec %0d memory access count", idx), acc_cnt - acc0, n_acc);
    if (first_wr >= 0)
      check(wr_log[wr0] == first_wr, v.cp ? "R5" : "R2",
            $sformatf("vec %0d first written address", idx), wr_log[wr0], first_wr);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int n_acc, first_wr, acc0;
    vec_t v;
    checks = 0; fails = 0; wr_cnt = 0; acc_cnt = 0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    for (int i = 0; i < NPIX; i++) begin
      mem[i]  = 8'((i * 37 + 11) & 8'hFF);
      expm[i] = mem[i];
    end
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd(RA_STATUS, r);
    check(r == 32'h0, "R1", "status after reset", int'(r), 0);
    check(acc_cnt == 0, "R1", "memory accesses after reset", acc_cnt, 0);

    // table of operations
    for (int k = 0; k < NVEC; k++) run_vec(VEC[k], k);

    // R3: empty fill (end x equal to start x)
    wr(RA_CLIP_LO, pack(0, 0));
    wr(RA_CLIP_HI, pack(31, 31));
    wr(RA_RECT, 32'd5); wr(RA_RECT, 32'd5); wr(RA_RECT, 32'd9);
    acc0 = acc_cnt;
    wr(RA_RECT, 32'd5);
    rd(RA_STATUS, r);
    check(r[BUSY_BIT] == 1'b0, "R3", "busy after empty fill", int'(r[BUSY_BIT]), 0);
    check(acc_cnt == acc0, "R3", "accesses for empty fill", acc_cnt - acc0, 0);

    // R3: empty copy (corner B left of corner A)
    wr(RA_SRC_A, pack(6, 6));
    wr(RA_SRC_B, pack(4, 8));
    acc0 = acc_cnt;
    rd(RA_BLIT, r);
    check(r == 32'h0, "R3", "empty copy accept word", int'(r), 0);
    rd(RA_STATUS, r);
    check(r[BUSY_BIT] == 1'b0 && acc_cnt == acc0, "R3", "empty copy idle and silent",
          acc_cnt - acc0, 0);
    cmp_mem("R3");

    // R7 / R8: long fill, then refused triggers
    v = '{1'b0, 5'd0, 5'd16, 5'd8, 5'd24, 5'd0, 5'd0, 5'd0, 5'd0, 5'd31, 5'd31, 8'h11, 8'hFF};
    model(v, n_acc, first_wr);
    wr(RA_FG, 32'h11);
    wr(RA_PMASK, 32'hFF);
    wr(RA_RECT, 32'd16); wr(RA_RECT, 32'd0); wr(RA_RECT, 32'd24);
    acc0 = acc_cnt;
    wr(RA_RECT, 32'd8);
    rd(RA_STATUS, r);
    check(r[BUSY_BIT] == 1'b1, "R7", "busy during fill", int'(r[BUSY_BIT]), 1);
    rd(RA_BLIT, r);
    check(r == 32'hB000_0000, "R8", "blit refusal word", int'(r), 32'hB000_0000);
    wr(RA_FG, 32'hEE);
    wr(RA_RECT, 32'd20); wr(RA_RECT, 32'd20); wr(RA_RECT, 32'd22);
    wr(RA_RECT, 32'd22);
    rd(RA_DRAW, r);
    check(r[REF_HI] && r[REF_LO], "R8", "draw refusal bits", int'(r[31:28]), 4'hA | int'(r[BUSY_BIT]));
    wait_idle("R8");
    cmp_mem("R8");
    check(acc_cnt - acc0 == n_acc, "R8", "accesses of surviving fill", acc_cnt - acc0, n_acc);

    // R8: accepted fill clears the refusal flag
    v = '{1'b0, 5'd30, 5'd30, 5'd31, 5'd31, 5'd0, 5'd0, 5'd0, 5'd0, 5'd31, 5'd31, 8'hEE, 8'hFF};
    model(v, n_acc, first_wr);
    wr(RA_RECT, 32'd30); wr(RA_RECT, 32'd30); wr(RA_RECT, 32'd31);
    wr(RA_RECT, 32'd31);
    wait_idle("R8");
    rd(RA_DRAW, r);
    check(r[REF_HI] == 1'b0 && r[REF_LO] == 1'b0, "R8", "draw bits after accepted fill",
          int'(r[31:28]), 0);
    cmp_mem("R2");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule